// File: doc/BRIEF.md
# AES Round-Key Synchronisation Controller

This controller sits beside a fully pipelined AES-128 datapath and decides when a new cipher key may move into it. Software writes the 128-bit key as four 32-bit words through a simple register-write port. Any single write may be the first, a middle or the last word of a key change, so every write is treated as a fresh key. The controller drives three things: the start of round-key expansion in the key store, the read index into that store, and a one-hot load enable that copies one round key into the local key register of one pipeline stage.

A small tracker follows stream transactions. A transaction opens when input valid is seen while idle, and closes on the handshake of the last output beat. The stages' local keys are reloaded only outside a transaction. The key store, however, may already expand the next key during a transaction, because the stages still hold their own copies of the old keys. Both the refresh and the expansion restart when another key word arrives. The one exception is a refresh that is already running when a transaction opens. That refresh runs to completion on the key it started with, and it blocks expansion until it finishes.

Top module: `aks_key_sync`

## Requirements
- R1: Key word n (address n, 0 to 3) occupies bits 32n+31 down to 32n of `key_o`. All words reset to zero, and a write changes only the addressed word.
- R2: Each accepted write sets a refresh-pending flag and an expansion-pending flag. Each flag stays set until its own process acknowledges it. A write in the same cycle as an acknowledge leaves the flag set.
- R3: From idle, `in_valid_i` high moves the tracker into the transaction state on the next edge, even while `in_hold_o` keeps the data from being accepted.
- R4: The tracker returns to idle on the edge where `out_valid_i`, `out_ready_i` and `out_last_i` are all high. Without the last-beat handshake, the transaction stays open.
- R5: A refresh starts only when refresh is pending and no transaction is open. `in_hold_o` is high from that start cycle until the refresh ends.
- R6: A refresh steps `rd_idx_o` from 0 to NR-1 and asserts only `load_en_o[rd_idx_o]` in each step. A step is taken only when `rk_valid_i[rd_idx_o]` is high and `exp_start_o` is low. The key store is expected to clear `rk_valid_i` on the edge that samples `exp_start_o`.
- R7: A refresh in progress restarts at index 0 when a write arrives outside a transaction. During a transaction, it continues on its current key.
- R8: `exp_start_o` is high for each cycle in which expansion is pending. The exception is while a refresh is running inside a transaction; then expansion start is withheld. During a transaction with no refresh, expansion starts.
- R9: `exp_start_o` acknowledges the expansion flag. `exp_busy_o` is high from the edge after a start until `rk_valid_i[NR-1]` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Key word write strobe |
| reg_addr_i | input | 2 | Key word index |
| reg_wdata_i | input | 32 | Key word data |
| key_o | output | 128 | Assembled key for the expansion unit |
| in_valid_i | input | 1 | Input stream valid |
| in_hold_o | output | 1 | Input must stall while stage keys reload |
| out_valid_i | input | 1 | Output stream valid |
| out_ready_i | input | 1 | Output stream ready |
| out_last_i | input | 1 | Output beat is the last one of the transaction |
| exp_start_o | output | 1 | Start or restart round-key expansion |
| exp_busy_o | output | 1 | Expansion running |
| rk_valid_i | input | 11 | Per-index valid of the key store entries |
| rd_idx_o | output | 4 | Key store read index |
| load_en_o | output | 11 | One-hot load enable of stage local keys |

## Verification
A tracker stuck in the transaction state shows up as a refresh that never begins after the last-beat handshake: the load enables stay silent and `in_hold_o` stays low. A tracker that leaves the transaction state too early shows up as loads arriving while the transaction is still open. Both faults are visible within a few cycles. A pending flag that is lost or cleared early skips the refresh sequence or the expansion start expected right after a write. An interlock fault shows in two ways: a load issued against a clear valid bit, which appears in the cycle of the load, or an expansion start emitted while a refresh runs inside a transaction, which appears in the cycle after the write.

// File: rtl/aks_pkg.sv
package aks_pkg;
  typedef enum logic {TXN_IDLE, TXN_OPEN} txn_state_e;
  typedef enum logic {RF_IDLE, RF_RUN} rf_state_e;
  typedef enum logic {EXP_IDLE, EXP_RUN} exp_state_e;
endpackage

// File: rtl/aks_key_regs.sv
module aks_key_regs #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  logic                    rf_ack_i,
  input  logic                    exp_ack_i,
  output logic [WORDS*WORD_W-1:0] key_o,
  output logic                    rf_pend_o,
  output logic                    exp_pend_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             word_q <= '0;
      else if (we_i && addr_i == AW'(w))       word_q <= wdata_i;
    end
    assign key_o[w*WORD_W +: WORD_W] = word_q;
  end

  // set wins over acknowledge: a write in the ack cycle is a new key
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_pend_o  <= 1'b0;
      exp_pend_o <= 1'b0;
    end else begin
      if (we_i)           rf_pend_o <= 1'b1;
      else if (rf_ack_i)  rf_pend_o <= 1'b0;
      if (we_i)           exp_pend_o <= 1'b1;
      else if (exp_ack_i) exp_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/aks_txn_tracker.sv
module aks_txn_tracker
  import aks_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_valid_i,
  input  logic out_ready_i,
  input  logic out_last_i,
  output logic txn_o
);
  txn_state_e state_q, state_d;
  logic       last_hs;

  assign last_hs = out_valid_i && out_ready_i && out_last_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TXN_IDLE: if (in_valid_i) state_d = TXN_OPEN;
      TXN_OPEN: if (last_hs)    state_d = TXN_IDLE;
      default:                  state_d = TXN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TXN_IDLE;
    else         state_q <= state_d;
  end

  assign txn_o = (state_q == TXN_OPEN);
endmodule

// File: rtl/aks_refresh_fsm.sv
module aks_refresh_fsm
  import aks_pkg::*;
#(
  parameter int unsigned NR   = 11,
  localparam int unsigned IDXW = $clog2(NR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            txn_i,
  input  logic            pend_i,
  input  logic            exp_start_i,
  input  logic [NR-1:0]   rk_valid_i,
  output logic            ack_o,
  output logic            busy_o,
  output logic [IDXW-1:0] idx_o,
  output logic [NR-1:0]   load_en_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NR - 1);

  rf_state_e       state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            restart, step;

  // (re)start is only legal outside a transaction
  assign restart = pend_i && !txn_i;
  assign ack_o   = restart;
  // valid bits are stale in the cycle expansion is (re)started
  assign step    = (state_q == RF_RUN) && !restart && !exp_start_i && rk_valid_i[idx_q];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (restart) begin
      state_d = RF_RUN;
      idx_d   = '0;
    end else if (step) begin
      if (idx_q == LAST) begin
        state_d = RF_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o    = (state_q == RF_RUN);
  assign idx_o     = idx_q;
  assign load_en_o = step ? (NR'(1) << idx_q) : '0;
endmodule

// File: rtl/aks_expand_fsm.sv
module aks_expand_fsm
  import aks_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txn_i,
  input  logic rf_busy_i,
  input  logic pend_i,
  input  logic last_valid_i,
  output logic start_o,
  output logic ack_o,
  output logic busy_o
);
  exp_state_e state_q, state_d;
  logic       allow;

  // stages still syncing inside a transaction: keep the store frozen
  assign allow   = !(rf_busy_i && txn_i);
  assign start_o = pend_i && allow;
  assign ack_o   = start_o;

  always_comb begin
    state_d = state_q;
    if (start_o)                                  state_d = EXP_RUN;
    else if (state_q == EXP_RUN && last_valid_i)  state_d = EXP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= EXP_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == EXP_RUN);
endmodule

// File: rtl/aks_key_sync.sv
module aks_key_sync #(
  parameter int unsigned NR     = 11,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AW    = $clog2(WORDS),
  localparam int unsigned IDXW  = $clog2(NR),
  localparam int unsigned KEY_W = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [KEY_W-1:0]  key_o,
  input  logic              in_valid_i,
  output logic              in_hold_o,
  input  logic              out_valid_i,
  input  logic              out_ready_i,
  input  logic              out_last_i,
  output logic              exp_start_o,
  output logic              exp_busy_o,
  input  logic [NR-1:0]     rk_valid_i,
  output logic [IDXW-1:0]   rd_idx_o,
  output logic [NR-1:0]     load_en_o
);
  logic txn, rf_pend, exp_pend, rf_ack, exp_ack, rf_busy;

  aks_key_regs #(.WORDS(WORDS), .WORD_W(WORD_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rf_ack_i  (rf_ack),
    .exp_ack_i (exp_ack),
    .key_o     (key_o),
    .rf_pend_o (rf_pend),
    .exp_pend_o(exp_pend)
  );

  aks_txn_tracker u_txn (
    .clk_i, .rst_ni,
    .in_valid_i, .out_valid_i, .out_ready_i, .out_last_i,
    .txn_o(txn)
  );

  aks_refresh_fsm #(.NR(NR)) u_rf (
    .clk_i, .rst_ni,
    .txn_i      (txn),
    .pend_i     (rf_pend),
    .exp_start_i(exp_start_o),
    .rk_valid_i (rk_valid_i),
    .ack_o      (rf_ack),
    .busy_o     (rf_busy),
    .idx_o      (rd_idx_o),
    .load_en_o  (load_en_o)
  );

  aks_expand_fsm u_exp (
    .clk_i, .rst_ni,
    .txn_i       (txn),
    .rf_busy_i   (rf_busy),
    .pend_i      (exp_pend),
    .last_valid_i(rk_valid_i[NR-1]),
    .start_o     (exp_start_o),
    .ack_o       (exp_ack),
    .busy_o      (exp_busy_o)
  );

  assign in_hold_o = rf_busy || rf_ack;
endmodule

// File: rtl/aks_key_sync_chk.sv
module aks_key_sync_chk #(
  parameter int unsigned NR   = 11,
  parameter int unsigned IDXW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic            in_valid_i,
  input logic            out_valid_i,
  input logic            out_ready_i,
  input logic            out_last_i,
  input logic            in_hold_o,
  input logic            exp_start_o,
  input logic [NR-1:0]   rk_valid_i,
  input logic [IDXW-1:0] rd_idx_o,
  input logic [NR-1:0]   load_en_o,
  input logic            txn_i,
  input logic            rf_busy_i,
  input logic            rf_pend_i,
  input logic            exp_pend_i
);
  p_pend_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (rf_pend_i && exp_pend_i));
  p_txn_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txn_i && in_valid_i) |=> txn_i);
  p_txn_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_i && out_valid_i && out_ready_i && out_last_i) |=> !txn_i);
  p_rf_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rf_busy_i && rf_pend_i && !txn_i) |=> rf_busy_i);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_busy_i |-> in_hold_o);
  p_load_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_en_o));
  p_load_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_o != '0) |-> (rk_valid_i[rd_idx_o] && !exp_start_o && load_en_o[rd_idx_o]));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_busy_i && rf_pend_i && !txn_i) |=> (rd_idx_o == '0));
  p_exp_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_busy_i && txn_i) |-> !exp_start_o);
  p_exp_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_start_o && !reg_we_i) |=> !exp_pend_i);
endmodule

bind aks_key_sync aks_key_sync_chk #(.NR(NR), .IDXW(IDXW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .in_valid_i (in_valid_i),
  .out_valid_i(out_valid_i),
  .out_ready_i(out_ready_i),
  .out_last_i (out_last_i),
  .in_hold_o  (in_hold_o),
  .exp_start_o(exp_start_o),
  .rk_valid_i (rk_valid_i),
  .rd_idx_o   (rd_idx_o),
  .load_en_o  (load_en_o),
  .txn_i      (txn),
  .rf_busy_i  (rf_busy),
  .rf_pend_i  (rf_pend),
  .exp_pend_i (exp_pend)
);

// File: tb/aks_key_sync_test.sv
`timescale 1ns/1ps
module aks_key_sync_test;
  localparam int NR = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [127:0]  key;
  logic          in_valid = 1'b0, in_hold;
  logic          out_valid = 1'b0, out_ready = 1'b0, out_last = 1'b0;
  logic          exp_start, exp_busy;
  logic [NR-1:0] rk_valid = '0;
  logic [3:0]    rd_idx;
  logic [NR-1:0] load_en;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  int limit = NR;
  int vcnt = 0;
  logic start_seen = 1'b0;
  logic done = 1'b0;
  logic [127:0] key_ref = '0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  aks_key_sync uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .key_o(key),
    .in_valid_i(in_valid), .in_hold_o(in_hold),
    .out_valid_i(out_valid), .out_ready_i(out_ready), .out_last_i(out_last),
    .exp_start_o(exp_start), .exp_busy_o(exp_busy),
    .rk_valid_i(rk_valid), .rd_idx_o(rd_idx), .load_en_o(load_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // key store model: clears on start, derives one entry per cycle up to limit
  always @(negedge clk) start_seen <= exp_start;
  always @(posedge clk) begin
    if (start_seen) begin
      rk_valid <= '0;
      vcnt     <= 0;
    end else if (vcnt < limit && vcnt < NR) begin
      rk_valid[vcnt] <= 1'b1;
      vcnt <= vcnt + 1;
    end
  end

  // monitor: scoreboard of stage loads, expansion start count
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_start) exp_cnt++;
      if (load_en != '0) begin
        check($countones(load_en) == 1, "R6", "load one-hot", load_en, 0);
        check(load_en[rd_idx] && rk_valid[rd_idx], "R6", "load on valid index", rd_idx, rd_idx);
        if (exp_q.size() == 0)
          check(1'b0, "R6", "unexpected load", rd_idx, 99);
        else begin
          int e;
          e = exp_q.pop_front();
          check(rd_idx == 4'(e), "R6", "load order", rd_idx, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 2'(a); wdata = d;
    key_ref[a*32 +: 32] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic push_seq(input int from, input int to);
    for (int i = from; i <= to; i++) exp_q.push_back(i);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_txn();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic close_txn();
    @(negedge clk); out_valid = 1'b1; out_ready = 1'b1; out_last = 1'b1;
    @(negedge clk); out_valid = 1'b0; out_ready = 1'b0; out_last = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(key == '0, "R1", "reset key", key[63:0], 0);
    check(!exp_start && !exp_busy && !in_hold && load_en == '0, "R5", "reset outputs",
          {exp_start, exp_busy, in_hold}, 0);

    // full key, no transaction: each write restarts expansion
    c0 = exp_cnt;
    push_seq(0, NR-1);
    @(negedge clk);
    we = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); wdata = 32'h1111_0000 * (a + 1) + 32'h0f0f;
      key_ref[a*32 +: 32] = wdata;
      @(negedge clk);
    end
    we = 1'b0;
    check(in_hold, "R5", "hold during refresh", in_hold, 1);
    idle(40);
    check(key == key_ref, "R1", "key layout", key[63:0], key_ref[63:0]);
    check(key[127:96] == key_ref[127:96], "R1", "top word", key[127:96], key_ref[127:96]);
    check(exp_cnt - c0 == 4, "R8", "start per write", exp_cnt - c0, 4);
    check(exp_q.size() == 0, "R6", "full refresh done", exp_q.size(), 0);
    check(!exp_busy && !in_hold, "R9", "idle after expansion", {exp_busy, in_hold}, 0);

    // restart of a refresh that has loaded part of the keys
    limit = 4;
    push_seq(0, 3);
    wr(1, 32'hdead_beef);
    idle(20);
    check(exp_q.size() == 0, "R6", "partial loads", exp_q.size(), 0);
    check(exp_busy, "R9", "busy while store incomplete", exp_busy, 1);
    check(in_hold && rd_idx == 4, "R6", "waits on clear valid", rd_idx, 4);
    push_seq(0, NR-1);
    wr(2, 32'hcafe_f00d);
    limit = NR;
    idle(40);
    check(exp_q.size() == 0, "R7", "restart from index 0", exp_q.size(), 0);
    check(key[95:64] == 32'hcafe_f00d, "R1", "single word update", key[95:64], 32'hcafe_f00d);

    // expansion during a transaction, refresh deferred to its end
    open_txn();
    c0 = exp_cnt;
    wr(3, 32'h0bad_c0de);
    idle(30);
    check(exp_cnt - c0 == 1, "R8", "expand inside transaction", exp_cnt - c0, 1);
    check(!in_hold, "R5", "no refresh inside transaction", in_hold, 0);
    check(!exp_busy, "R9", "expansion completed", exp_busy, 0);
    push_seq(0, NR-1);
    close_txn();
    idle(30);
    check(exp_q.size() == 0, "R4", "refresh after last beat", exp_q.size(), 0);

    // output beats without the last-beat handshake keep the transaction open
    open_txn();
    wr(0, 32'h1234_5678);
    @(negedge clk); out_valid = 1'b1; out_last = 1'b1; out_ready = 1'b0;
    idle(10);
    out_last = 1'b0; out_ready = 1'b1;
    idle(10);
    out_valid = 1'b0; out_ready = 1'b0;
    idle(3);
    check(!in_hold, "R4", "open without last handshake", in_hold, 0);
    push_seq(0, NR-1);
    close_txn();
    idle(30);
    check(exp_q.size() == 0, "R4", "refresh after delayed last", exp_q.size(), 0);

    // transaction opens during a refresh: refresh finishes, expansion blocked
    limit = 2;
    push_seq(0, 1);
    wr(3, 32'h5555_aaaa);
    idle(15);
    check(in_hold && exp_q.size() == 0, "R5", "held at index 2", rd_idx, 2);
    open_txn();
    c0 = exp_cnt;
    wr(1, 32'h7777_1111);
    idle(10);
    check(exp_cnt - c0 == 0, "R8", "expansion withheld", exp_cnt - c0, 0);
    check(rd_idx == 2, "R7", "no restart inside transaction", rd_idx, 2);
    check(in_hold, "R3", "held input still opened transaction", in_hold, 1);
    push_seq(2, NR-1);
    limit = NR;
    idle(40);
    check(exp_q.size() == 0, "R7", "old refresh completed", exp_q.size(), 0);
    check(exp_cnt - c0 == 1, "R2", "pending kept through block", exp_cnt - c0, 1);
    check(!in_hold, "R5", "no new refresh inside transaction", in_hold, 0);
    push_seq(0, NR-1);
    close_txn();
    idle(40);
    check(exp_q.size() == 0, "R2", "deferred refresh ran", exp_q.size(), 0);
    check(key == key_ref, "R1", "final key", key[127:64], key_ref[127:64]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule